// File: doc/BRIEF.md
# Threshold Offset Programming Port

This block owns the two threshold offsets that a FIFO flag unit compares its fill level against. One offset measures distance from the empty boundary and the other distance from the full boundary. Both are driven continuously on `ae_ofs` and `af_ofs`.

At master reset a three-bit index picks one of eight default values, and both offsets take that value. The index is formed from `dflt_sel` and the `ld_strobe` pin. The same reset latches the loading method from `ser_mode_in`.

After reset, software or a sequencer can rewrite the offsets in one of two ways:
- **Serial:** one bit per clock is shifted in while `ser_en` and `ld_strobe` are both high.
- **Parallel:** one word per clock is written while `wr_en` and `ld_strobe` are both high.

In either method, readback is a word per clock while `rd_en` and `ld_strobe` are both high. Partial reset rewinds the access positions but keeps the offsets and the method.

The load and readback paths are strobe-gated control pins with no back-pressure. Every qualified request is consumed in the cycle it is seen. `rd_valid` marks the single cycle in which a readback word is presented, and there is no ready input. Read and write share one clock.

Top module: `ofs_prog_port`

## Requirements
- R1: While `rst_master` is high, both offsets take the default value 2^(k+3)-1, where k = {ld_strobe, dflt_sel[1:0]}. For example, k=0 gives 7, k=5 gives 255 and k=7 gives 1023.
- R2: The loading method is latched from `ser_mode_in` during master reset (1 = serial, 0 = parallel). It does not change until the next master reset.
- R3: In serial mode, each clock with `ser_en` and `ld_strobe` high stores `ser_in` into the next bit position. Bits go LSB first, first into bits 0..W-1 of the empty offset and then into bits 0..W-1 of the full offset. After 2W bits the position wraps to bit 0 of the empty offset.
- R4: In parallel mode, each clock with `wr_en` and `ld_strobe` high writes `wr_data` to one offset. Writes alternate between the two offsets, beginning with the empty offset.
- R5: Requests for the method not selected are ignored, and the offsets keep their values. This covers a serial shift in parallel mode and a parallel write in serial mode.
- R6: A clock with `rd_en` and `ld_strobe` high produces a readback word in either mode. In the following cycle `rd_data` holds an offset and `rd_valid` is 1. Reads alternate between the two offsets, beginning with the empty offset.
- R7: Partial reset keeps both offsets and the method. It returns the write position, the read position and the serial bit position to the start of the empty offset.
- R8: Without `ld_strobe`, `wr_en` and `ser_en` change no offset.
- R9: `rd_valid` is 0 in every cycle not preceded by a readback request, and is 0 after either reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all registers |
| rst_master | input | 1 | Synchronous master reset, active high |
| rst_partial | input | 1 | Synchronous partial reset, active high |
| dflt_sel | input | 2 | Low bits of the default index |
| ser_mode_in | input | 1 | Loading method, sampled at master reset |
| ld_strobe | input | 1 | Load/readback qualifier; top bit of the default index during master reset |
| wr_en | input | 1 | Parallel write request |
| wr_data | input | OFS_W | Parallel write word |
| ser_en | input | 1 | Serial shift request |
| ser_in | input | 1 | Serial data bit |
| rd_en | input | 1 | Readback request |
| rd_data | output | OFS_W | Readback word |
| rd_valid | output | 1 | Readback word present this cycle |
| ae_ofs | output | OFS_W | Almost-empty offset |
| af_ofs | output | OFS_W | Almost-full offset |

## Verification
The hardest state to reach is the serial bit position after the wrap. It can only be reached by shifting exactly 2W bits and then one more. The check is that the extra bit lands in bit 0 of the empty offset while the full offset stays unchanged. The serial scenario shifts a full 20-bit pattern, checks both offsets, then shifts one more bit. A later scenario applies partial reset mid-sequence and shows that the next serial bit or parallel word again lands in the empty offset.

// File: rtl/ofs_pkg.sv
package ofs_pkg;
  localparam int DFLT_IDX_W = 3;

  function automatic logic [31:0] dflt_of(logic [DFLT_IDX_W-1:0] idx);
    logic [31:0] sh;
    sh = {29'd0, idx} + 32'd3;
    return (32'd1 << sh) - 32'd1;
  endfunction
endpackage

// File: rtl/ofs_serial_shift.sv
module ofs_serial_shift #(
  parameter int OFS_W = 10
) (
  input  logic             clk,
  input  logic             rst_any,
  input  logic             shift_req,
  output logic [OFS_W-1:0] ae_bit_we,
  output logic [OFS_W-1:0] af_bit_we
);
  localparam int NBITS = 2 * OFS_W;
  localparam int CW    = $clog2(NBITS);
  localparam logic [CW-1:0] LAST = CW'(NBITS - 1);

  logic [CW-1:0] pos_q;

  always_ff @(posedge clk) begin
    if (rst_any)                 pos_q <= '0;
    else if (shift_req)          pos_q <= (pos_q == LAST) ? '0 : pos_q + 1'b1;
  end

  for (genvar i = 0; i < OFS_W; i++) begin : g_dec
    assign ae_bit_we[i] = shift_req && (pos_q == CW'(i));
    assign af_bit_we[i] = shift_req && (pos_q == CW'(i + OFS_W));
  end

  p_pos_range_r3: assert property (@(posedge clk) disable iff (rst_any)
    pos_q <= LAST);
  p_wrap_r3: assert property (@(posedge clk) disable iff (rst_any)
    (shift_req && pos_q == LAST) |=> pos_q == '0);
  p_onehot_r3: assert property (@(posedge clk) disable iff (rst_any)
    $onehot0({ae_bit_we, af_bit_we}));
endmodule

// File: rtl/ofs_par_port.sv
module ofs_par_port (
  input  logic clk,
  input  logic rst_any,
  input  logic wr_req,
  input  logic rd_req,
  output logic wr_ae,
  output logic wr_af,
  output logic rd_pick_af
);
  logic wr_tog_q, rd_tog_q;

  always_ff @(posedge clk) begin
    if (rst_any) begin
      wr_tog_q <= 1'b0;
      rd_tog_q <= 1'b0;
    end else begin
      if (wr_req) wr_tog_q <= ~wr_tog_q;
      if (rd_req) rd_tog_q <= ~rd_tog_q;
    end
  end

  assign wr_ae      = wr_req && !wr_tog_q;
  assign wr_af      = wr_req &&  wr_tog_q;
  assign rd_pick_af = rd_tog_q;

  p_alt_wr_r4: assert property (@(posedge clk) disable iff (rst_any)
    wr_ae |=> !wr_ae);
  p_alt_rd_r6: assert property (@(posedge clk) disable iff (rst_any)
    rd_req |=> (rd_pick_af != $past(rd_pick_af)));
endmodule

// File: rtl/ofs_regs.sv
module ofs_regs #(
  parameter int OFS_W = 10
) (
  input  logic             clk,
  input  logic             rst_master,
  input  logic [OFS_W-1:0] dflt_val,
  input  logic             par_we_ae,
  input  logic             par_we_af,
  input  logic [OFS_W-1:0] par_data,
  input  logic [OFS_W-1:0] ser_we_ae,
  input  logic [OFS_W-1:0] ser_we_af,
  input  logic             ser_bit,
  output logic [OFS_W-1:0] ae_q,
  output logic [OFS_W-1:0] af_q
);
  for (genvar i = 0; i < OFS_W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst_master)        ae_q[i] <= dflt_val[i];
      else if (par_we_ae)    ae_q[i] <= par_data[i];
      else if (ser_we_ae[i]) ae_q[i] <= ser_bit;
    end
    always_ff @(posedge clk) begin
      if (rst_master)        af_q[i] <= dflt_val[i];
      else if (par_we_af)    af_q[i] <= par_data[i];
      else if (ser_we_af[i]) af_q[i] <= ser_bit;
    end
  end

  p_hold_ae_r8: assert property (@(posedge clk) disable iff (rst_master)
    (!par_we_ae && ser_we_ae == '0) |=> $stable(ae_q));
  p_hold_af_r8: assert property (@(posedge clk) disable iff (rst_master)
    (!par_we_af && ser_we_af == '0) |=> $stable(af_q));
endmodule

// File: rtl/ofs_prog_port.sv
module ofs_prog_port #(
  parameter int OFS_W = 10
) (
  input  logic             clk,
  input  logic             rst_master,
  input  logic             rst_partial,
  input  logic [1:0]       dflt_sel,
  input  logic             ser_mode_in,
  input  logic             ld_strobe,
  input  logic             wr_en,
  input  logic [OFS_W-1:0] wr_data,
  input  logic             ser_en,
  input  logic             ser_in,
  input  logic             rd_en,
  output logic [OFS_W-1:0] rd_data,
  output logic             rd_valid,
  output logic [OFS_W-1:0] ae_ofs,
  output logic [OFS_W-1:0] af_ofs
);
  import ofs_pkg::*;

  logic             rst_any;
  logic             mode_ser_q;
  logic             ser_req, wr_req, rd_req;
  logic             wr_ae, wr_af, rd_pick_af;
  logic [OFS_W-1:0] ae_bit_we, af_bit_we;
  logic [OFS_W-1:0] dflt_val;
  logic [31:0]      dflt_full;

  assign rst_any   = rst_master || rst_partial;
  assign dflt_full = dflt_of({ld_strobe, dflt_sel});
  assign dflt_val  = dflt_full[OFS_W-1:0];

  always_ff @(posedge clk) begin
    if (rst_master) mode_ser_q <= ser_mode_in;
  end

  assign ser_req = !rst_any &&  mode_ser_q && ser_en && ld_strobe;
  assign wr_req  = !rst_any && !mode_ser_q && wr_en  && ld_strobe;
  assign rd_req  = !rst_any && rd_en && ld_strobe;

  ofs_serial_shift #(.OFS_W(OFS_W)) u_ser (
    .clk(clk), .rst_any(rst_any), .shift_req(ser_req),
    .ae_bit_we(ae_bit_we), .af_bit_we(af_bit_we)
  );

  ofs_par_port u_par (
    .clk(clk), .rst_any(rst_any), .wr_req(wr_req), .rd_req(rd_req),
    .wr_ae(wr_ae), .wr_af(wr_af), .rd_pick_af(rd_pick_af)
  );

  ofs_regs #(.OFS_W(OFS_W)) u_regs (
    .clk(clk), .rst_master(rst_master), .dflt_val(dflt_val),
    .par_we_ae(wr_ae), .par_we_af(wr_af), .par_data(wr_data),
    .ser_we_ae(ae_bit_we), .ser_we_af(af_bit_we), .ser_bit(ser_in),
    .ae_q(ae_ofs), .af_q(af_ofs)
  );

  always_ff @(posedge clk) begin
    if (rst_master) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else if (rst_partial) begin
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_req;
      if (rd_req) rd_data <= rd_pick_af ? af_ofs : ae_ofs;
    end
  end

  p_mode_hold_r2: assert property (@(posedge clk) disable iff (rst_master)
    1'b1 |=> $stable(mode_ser_q));
  p_dflt_pair_r1: assert property (@(posedge clk) disable iff (rst_partial)
    rst_master |=> (ae_ofs == af_ofs));
  p_rd_valid_r6: assert property (@(posedge clk) disable iff (rst_any)
    rd_req |=> rd_valid);
  p_rd_quiet_r9: assert property (@(posedge clk) disable iff (rst_any)
    !rd_req |=> !rd_valid);
  p_ignore_par_r5: assert property (@(posedge clk) disable iff (rst_any)
    (mode_ser_q && !ser_en) |=> ($stable(ae_ofs) && $stable(af_ofs)));
  p_ignore_ser_r5: assert property (@(posedge clk) disable iff (rst_any)
    (!mode_ser_q && !(wr_en && ld_strobe)) |=> ($stable(ae_ofs) && $stable(af_ofs)));
endmodule

// File: tb/sim_ofs_prog_port.sv
module sim_ofs_prog_port;
  localparam int CLK_PERIOD = 10;
  localparam int W = 10;

  logic         clk = 1'b0;
  logic         rst_master = 1'b1, rst_partial = 1'b0;
  logic [1:0]   dflt_sel = 2'b01;
  logic         ser_mode_in = 1'b0, ld_strobe = 1'b1;
  logic         wr_en = 1'b0, ser_en = 1'b0, ser_in = 1'b0, rd_en = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] rd_data, ae_ofs, af_ofs;
  logic         rd_valid;

  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ofs_prog_port #(.OFS_W(W)) u0 (
    .clk(clk), .rst_master(rst_master), .rst_partial(rst_partial),
    .dflt_sel(dflt_sel), .ser_mode_in(ser_mode_in), .ld_strobe(ld_strobe),
    .wr_en(wr_en), .wr_data(wr_data), .ser_en(ser_en), .ser_in(ser_in),
    .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid),
    .ae_ofs(ae_ofs), .af_ofs(af_ofs)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic idle();
    wr_en = 0; ser_en = 0; rd_en = 0; rst_master = 0; rst_partial = 0; ld_strobe = 0;
  endtask

  task automatic do_master(logic [2:0] k, logic smode);
    rst_master = 1; {ld_strobe, dflt_sel} = k; ser_mode_in = smode;
    step(); step();
    idle(); ser_mode_in = ~smode;
    step();
  endtask

  task automatic par_write(logic [W-1:0] v);
    wr_en = 1; ld_strobe = 1; wr_data = v; step(); idle();
  endtask

  task automatic ser_shift(logic [2*W-1:0] v, int n);
    for (int i = 0; i < n; i++) begin
      ser_en = 1; ld_strobe = 1; ser_in = v[i]; step();
    end
    idle();
  endtask

  task automatic read_one(string req, int exp);
    rd_en = 1; ld_strobe = 1; step(); idle();
    chk(req, int'(rd_valid), 1);
    chk(req, int'(rd_data), exp);
    step();
    chk("R9", int'(rd_valid), 0);
  endtask

  task automatic t_reset_defaults();
    step(); step(); idle(); step();
    chk("R1", int'(ae_ofs), 255);
    chk("R1", int'(af_ofs), 255);
    chk("R9", int'(rd_valid), 0);
  endtask

  task automatic t_parallel();
    par_write(10'h123);
    chk("R4", int'(ae_ofs), 'h123);
    chk("R4", int'(af_ofs), 255);
    par_write(10'h0A5);
    chk("R4", int'(af_ofs), 'h0A5);
    wr_en = 1; ld_strobe = 0; wr_data = 10'h3FF; ser_en = 1; step(); idle();
    chk("R8", int'(ae_ofs), 'h123);
    chk("R8", int'(af_ofs), 'h0A5);
    ser_shift(20'h00000, 20);
    chk("R5", int'(ae_ofs), 'h123);
    chk("R5", int'(af_ofs), 'h0A5);
    read_one("R6", 'h123);
    read_one("R6", 'h0A5);
  endtask

  task automatic t_partial_par();
    par_write(10'h011);
    rst_partial = 1; step(); idle(); step();
    chk("R7", int'(ae_ofs), 'h011);
    chk("R7", int'(af_ofs), 'h0A5);
    par_write(10'h022);
    chk("R7", int'(ae_ofs), 'h022);
    chk("R7", int'(af_ofs), 'h0A5);
  endtask

  task automatic t_serial();
    do_master(3'd0, 1'b1);
    chk("R1", int'(ae_ofs), 7);
    chk("R1", int'(af_ofs), 7);
    par_write(10'h155);
    chk("R5", int'(ae_ofs), 7);
    chk("R2", int'(af_ofs), 7);
    ser_shift({10'h15A, 10'h2C3}, 20);
    chk("R3", int'(ae_ofs), 'h2C3);
    chk("R3", int'(af_ofs), 'h15A);
    ser_shift(20'h0, 1);
    chk("R3", int'(ae_ofs), 'h2C2);
    chk("R3", int'(af_ofs), 'h15A);
    read_one("R6", 'h2C2);
    read_one("R6", 'h15A);
  endtask

  task automatic t_partial_ser();
    do_master(3'd7, 1'b1);
    chk("R1", int'(ae_ofs), 1023);
    ser_shift(20'h0, 3);
    chk("R3", int'(ae_ofs), 1016);
    rst_partial = 1; step(); idle(); step();
    chk("R7", int'(ae_ofs), 1016);
    ser_shift(20'h0, 10);
    chk("R7", int'(ae_ofs), 0);
    chk("R2", int'(af_ofs), 1023);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 20000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_master = 1; dflt_sel = 2'b01; ld_strobe = 1; ser_mode_in = 0;
    t_reset_defaults();
    t_parallel();
    t_partial_par();
    t_serial();
    t_partial_ser();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule